// File: doc/BRIEF.md
# Saturating Command Accumulator

This block keeps one signed command value, such as a torque or velocity setpoint, in a register and changes it by a signed step on any cycle where a step is requested. One select bit chooses whether the step is added or subtracted. Both operations use the same adder. For subtraction the adder receives the bitwise inverse of the step and a carry-in of one. One overflow detector serves both operations.

When an update would leave the signed range, the block clamps the value at the nearest limit by default, so a command at full scale cannot flip to the opposite full scale. A mode input selects plain modulo wrapping instead, which is useful for comparison. Two registered flags report whether the last update clamped at the top or at the bottom of the range. A synchronous load writes a new value directly.

Top module: `sat_cmd_acc`

## Requirements
- R1: While reset is asserted, and after it is released, the command output reads 0 and both clamp flags read 0 until the first update.
- R2: With `load_i` high, the register takes `load_val_i` on the next clock and both flags clear, whatever `step_i` is.
- R3: With `step_i` high and `op_sub_i` = 0, the register becomes its old value plus `delta_i` (signed) when the exact sum lies in [-2048, +2047].
- R4: With `step_i` high and `op_sub_i` = 1, the register becomes its old value minus `delta_i` when the exact difference lies in range.
- R5: Signed overflow is flagged exactly when the carry into the top bit differs from the carry out of it. With `wrap_mode_i` = 0, an overflowing update stores +2047 if the old value was non-negative and -2048 if it was negative.
- R6: `sat_hi_o` is 1 after an update that clamped to +2047, and `sat_lo_o` is 1 after one that clamped to -2048. The two flags are never 1 together, and any update that does not clamp clears both.
- R7: With `wrap_mode_i` = 1, the result is the exact sum or difference taken modulo 4096 and read as signed, so +2047 plus 1 gives -2048. Both flags read 0 after such an update.
- R8: Subtracting -2048 from 0 gives -2048 in wrapping mode. In clamping mode it gives +2047 with `sat_hi_o` set.
- R9: With `load_i` and `step_i` both low, the command and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Write `load_val_i` into the register |
| load_val_i | input | 12 | Signed value to load |
| step_i | input | 1 | Apply one add or subtract step |
| op_sub_i | input | 1 | 0 = add `delta_i`, 1 = subtract `delta_i` |
| wrap_mode_i | input | 1 | 0 = clamp on overflow, 1 = wrap modulo 2^W |
| delta_i | input | 12 | Signed step |
| cmd_o | output | 12 | Registered signed command value |
| sat_hi_o | output | 1 | Last update clamped at the positive limit |
| sat_lo_o | output | 1 | Last update clamped at the negative limit |

## Verification
The bench drives the register to +2047 and then adds 1, once in each mode. A design that only wraps would jump to -2048 in clamping mode. It also subtracts -2048 from 0: an overflow detector that ignores the operation select would miss this case, and a clamp that takes its direction from the raw sum would pin the value low. It further checks that load wins over a simultaneous step, that idle cycles leave the flags alone, and that a normal update clears a stale flag. Long runs with large random steps, compared every cycle against an integer model, catch wrong carry wiring and flags that are set in the wrong direction.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } acc_op_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } clamp_flags_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/acc_addsub_core.sv
module acc_addsub_core #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_top_in_o,
  output logic         c_top_out_o
);

  localparam int LW = W - 1;

  logic [W-1:0] b_eff;
  logic [LW:0]  low_sum;
  logic [1:0]   top_sum;

  // subtraction: inverted operand plus carry-in of one
  assign b_eff = b_i ^ {W{sub_i}};

  always_comb begin
    low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, sub_i};
    top_sum = {1'b0, a_i[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, low_sum[LW]};
  end

  assign sum_o       = {top_sum[0], low_sum[LW-1:0]};
  assign c_top_in_o  = low_sum[LW];
  assign c_top_out_o = top_sum[1];

endmodule

// File: rtl/acc_clamp_sel.sv
module acc_clamp_sel
  import sat_acc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0]  sum_i,
  input  logic          ovf_i,
  input  logic          neg_dir_i,
  input  logic          wrap_i,
  output logic [W-1:0]  res_o,
  output clamp_flags_t  flags_o
);

  localparam logic [W-1:0] LIM_HI = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LIM_LO = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    res_o   = sum_i;
    flags_o = '0;
    if (ovf_i && !wrap_i) begin
      if (neg_dir_i) begin
        res_o      = LIM_LO;
        flags_o.lo = 1'b1;
      end else begin
        res_o      = LIM_HI;
        flags_o.hi = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_cmd_acc.sv
module sat_cmd_acc
  import sat_acc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         op_sub_i,
  input  logic         wrap_mode_i,
  input  logic [W-1:0] delta_i,
  output logic [W-1:0] cmd_o,
  output logic         sat_hi_o,
  output logic         sat_lo_o
);

  localparam logic [W-1:0] CMD_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] CMD_MIN = {1'b1, {(W-1){1'b0}}};

  logic         rst_sync_n;
  logic [W-1:0] cmd_q, cmd_d;
  clamp_flags_t flg_q, flg_d;
  logic [W-1:0] raw_sum, step_res;
  logic         c_in, c_out, ovf, upd_en;
  clamp_flags_t step_flags;
  acc_op_e      op;

  assign op = acc_op_e'(op_sub_i);

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  acc_addsub_core #(.W(W)) u_core (
    .a_i         (cmd_q),
    .b_i         (delta_i),
    .sub_i       (op == OP_SUB),
    .sum_o       (raw_sum),
    .c_top_in_o  (c_in),
    .c_top_out_o (c_out)
  );

  // unified overflow for add and subtract
  assign ovf = c_in ^ c_out;

  acc_clamp_sel #(.W(W)) u_clamp (
    .sum_i     (raw_sum),
    .ovf_i     (ovf),
    .neg_dir_i (cmd_q[W-1]),
    .wrap_i    (wrap_mode_i),
    .res_o     (step_res),
    .flags_o   (step_flags)
  );

  assign upd_en = load_i | step_i;

  always_comb begin
    if (load_i) begin
      cmd_d = load_val_i;
      flg_d = '0;
    end else begin
      cmd_d = step_res;
      flg_d = step_flags;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q <= '0;
      flg_q <= '0;
    end else if (upd_en) begin
      cmd_q <= cmd_d;
      flg_q <= flg_d;
    end
  end

  assign cmd_o    = cmd_q;
  assign sat_hi_o = flg_q.hi;
  assign sat_lo_o = flg_q.lo;

  // carry-based detection agrees with the operand-sign rule (R5)
  p_ovf_sign_rule_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ovf == ((cmd_q[W-1] == (delta_i[W-1] ^ op_sub_i)) && (raw_sum[W-1] != cmd_q[W-1])));

  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(sat_hi_o && sat_lo_o));

  p_hi_at_max_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sat_hi_o |-> cmd_o == CMD_MAX);

  p_lo_at_min_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sat_lo_o |-> cmd_o == CMD_MIN);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    load_i |=> (cmd_o == $past(load_val_i)) && !sat_hi_o && !sat_lo_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!load_i && !step_i) |=> $stable(cmd_o) && $stable(sat_hi_o) && $stable(sat_lo_o));

  p_no_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!load_i && step_i && !wrap_mode_i && cmd_o == CMD_MAX && !op_sub_i && !delta_i[W-1])
      |=> cmd_o == CMD_MAX);

  p_wrap_noflag_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!load_i && step_i && wrap_mode_i) |=> !sat_hi_o && !sat_lo_o);

endmodule

// File: tb/sat_cmd_acc_tb.sv
module sat_cmd_acc_tb;

  localparam int W    = 12;
  localparam int VMAX = 2047;
  localparam int VMIN = -2048;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         load_i, step_i, op_sub_i, wrap_mode_i;
  logic [W-1:0] load_val_i, delta_i;
  logic [W-1:0] cmd_o;
  logic         sat_hi_o, sat_lo_o;

  always #2 clk = ~clk;

  sat_cmd_acc #(.W(W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .step_i      (step_i),
    .op_sub_i    (op_sub_i),
    .wrap_mode_i (wrap_mode_i),
    .delta_i     (delta_i),
    .cmd_o       (cmd_o),
    .sat_hi_o    (sat_hi_o),
    .sat_lo_o    (sat_lo_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_cmd = 0;
  bit    m_hi  = 0;
  bit    m_lo  = 0;
  string m_tag = "R1";
  bit    done  = 0;

  task automatic compare();
    n_cmp++;
    if ($signed(cmd_o) !== m_cmd) begin
      n_bad++;
      $display("FAIL %s cmd actual %0d expected %0d", m_tag, $signed(cmd_o), m_cmd);
    end
    n_cmp++;
    if (sat_hi_o !== m_hi || sat_lo_o !== m_lo) begin
      n_bad++;
      $display("FAIL R6/%s flags actual hi=%b lo=%b expected hi=%b lo=%b",
               m_tag, sat_hi_o, sat_lo_o, m_hi, m_lo);
    end
  endtask

  // one cycle: check previous result, drive new inputs, advance model
  task automatic apply(bit ld, int lv, bit st, bit sb, bit wr, int d);
    int exact;
    @(negedge clk);
    compare();
    load_i      = ld;
    load_val_i  = lv[W-1:0];
    step_i      = st;
    op_sub_i    = sb;
    wrap_mode_i = wr;
    delta_i     = d[W-1:0];
    if (ld) begin
      m_tag = "R2"; m_cmd = lv; m_hi = 0; m_lo = 0;
    end else if (st) begin
      exact = sb ? m_cmd - d : m_cmd + d;
      if (sb && d == VMIN && m_cmd == 0) m_tag = "R8";
      else if (wr) m_tag = "R7";
      else if (exact > VMAX || exact < VMIN) m_tag = "R5";
      else m_tag = sb ? "R4" : "R3";
      m_hi = 0; m_lo = 0;
      if (exact > VMAX || exact < VMIN) begin
        if (wr) begin
          m_cmd = (exact > VMAX) ? exact - 4096 : exact + 4096;
        end else if (m_cmd >= 0) begin
          m_cmd = VMAX; m_hi = 1;
        end else begin
          m_cmd = VMIN; m_lo = 1;
        end
      end else begin
        m_cmd = exact;
      end
    end else begin
      m_tag = "R9";
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; load_i = 0; load_val_i = '0; step_i = 0;
    op_sub_i = 0; wrap_mode_i = 0; delta_i = '0;
    repeat (3) @(negedge clk);
    m_tag = "R1";
    compare();
    // load attempted during reset must not stick (R1)
    load_i = 1; load_val_i = 12'd77;
    @(negedge clk);
    compare();
    load_i = 0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    compare();

    apply(1, 2000, 0, 0, 0, 0);      // R2
    apply(0, 0, 1, 0, 0, 47);        // R3 reaches +2047
    apply(0, 0, 1, 0, 0, 1);         // R5 clamp high
    apply(0, 0, 0, 0, 0, 5);         // R9 flag held
    apply(0, 0, 1, 0, 1, 1);         // R7 wraps to -2048
    apply(0, 0, 1, 1, 0, 1);         // R5 clamp low
    apply(0, 0, 1, 1, 0, -100);      // R4 clears flag
    apply(1, 0, 0, 0, 0, 0);
    apply(0, 0, 1, 1, 1, VMIN);      // R8 wrap
    apply(1, 0, 0, 0, 0, 0);
    apply(0, 0, 1, 1, 0, VMIN);      // R8 clamp high
    apply(0, 0, 1, 1, 0, 5);         // R4
    apply(1, -300, 1, 0, 0, 1000);   // R2 load wins
    apply(1, 100, 0, 0, 0, 0);
    apply(0, 0, 1, 1, 0, VMIN);      // R5 via subtract
    apply(1, -1, 0, 0, 0, 0);
    apply(0, 0, 1, 1, 0, VMAX);      // R4 -1-2047 = -2048 exact
    apply(0, 0, 1, 0, 0, VMIN);      // R5 clamp low on add

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 15));
      apply(r == 0, int'($urandom_range(0, 4095)) - 2048, r > 3,
            $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
            int'($urandom_range(0, 4095)) - 2048);
    end
    apply(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule